// File: doc/BRIEF.md
# Mesochronous Clock-Crossing FIFO

This block carries a stream of data words from a source clock domain into a destination clock domain when both clocks run at the same frequency but with an unknown relative phase that may wander slowly over time. The source side pushes one word per cycle with a write enable. The destination side does not pop on demand. Instead, once the queue is seen to hold data, it waits a fixed guard interval and then pops on every destination cycle without looking at the empty state again. Because the rates match, the fill level then stays roughly constant. The guard margin absorbs phase drift in either direction.

Each domain keeps its own binary pointer and a Gray-coded copy of it. The Gray copy passes into the other domain through a two-stage synchronizer. Full and empty are derived from these synchronized copies. The storage is a small register array with one write port and one read port. Two sticky error flags report a write attempted while full and a pop taken while empty. Each domain has an active-low asynchronous reset whose release is assumed to be synchronous to that domain's clock.

Top module: `meso_fifo`

## Requirements
- R1: While its domain's reset is low, and on the first cycles after release, the block shows `rd_empty`=1, `rd_valid`=0, `rd_udf_err`=0, `wr_full`=0 and `wr_ovf_err`=0. Releasing the write reset clears `wr_ovf_err`.
- R2: Every word accepted on the write port appears on `rd_data` exactly once, in the order it was written. This holds for any fixed phase offset between the clocks and across a small phase step during streaming.
- R3: Let edge E be the last read-clock rising edge before `rd_empty` is first seen low after reset. `rd_valid` first goes high just after read-clock rising edge E+GUARD+2, where GUARD is a parameter with default 4.
- R4: After `rd_valid` first rises, it stays high on every read-clock cycle until read reset, whatever `rd_empty` does.
- R5: With the reader held in reset, `wr_full` stays low after DEPTH-1 accepted writes and goes high right after the DEPTH-th. DEPTH is a parameter with default 64.
- R6: A write attempted while `wr_full` is high is dropped. It changes no stored word, and the DEPTH words already stored are still read out unchanged, in order.
- R7: `wr_ovf_err` rises on the write-clock edge that sees a write attempt while full. It then stays high until write reset.
- R8: `rd_udf_err` stays low while the writer keeps pace. It goes high once a pop is taken while the queue is empty, which happens after the writer stops, and stays high until read reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Source-domain clock |
| wr_rst_n | input | 1 | Source-domain active-low reset |
| wr_en | input | 1 | Write request for the current source cycle |
| wr_data | input | DATA_W | Word to store |
| wr_full | output | 1 | Queue holds DEPTH unread words; writes are dropped |
| wr_ovf_err | output | 1 | Sticky flag: a write was attempted while full |
| rd_clk | input | 1 | Destination-domain clock |
| rd_rst_n | input | 1 | Destination-domain active-low reset |
| rd_valid | output | 1 | `rd_data` carries a popped word this cycle |
| rd_data | output | DATA_W | Popped word, registered |
| rd_empty | output | 1 | Synchronized view: no unread words |
| rd_udf_err | output | 1 | Sticky flag: a pop was taken while empty |

## Verification
A corrupted pointer or a bad synchronized copy shows up at the ports within a few words. The read stream would skip, repeat or reorder values against the counting pattern the bench writes, or the underflow flag would rise while the writer is still keeping pace. A wrong guard counter or start state moves the first `rd_valid` away from its exact expected edge, and a bad run state drops `rd_valid` mid-stream, so either fault is visible in the first cycles of reading. A wrong full comparison, or a write that slips through while full, changes the cycle at which `wr_full` rises or overwrites the oldest word, and the first word read out then shows it.

// File: rtl/meso_fifo_pkg.sv
package meso_fifo_pkg;

  typedef enum logic [1:0] {
    RD_IDLE  = 2'd0,
    RD_GUARD = 2'd1,
    RD_RUN   = 2'd2
  } rd_state_e;

endpackage

// File: rtl/meso_sync.sv
module meso_sync #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] meta_q;
  logic [W-1:0] stab_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      stab_q <= '0;
    end else begin
      meta_q <= d;
      stab_q <= meta_q;
    end
  end

  assign q = stab_q;

endmodule

// File: rtl/meso_mem.sv
module meso_mem #(
  parameter int DATA_W = 16,
  parameter int DEPTH  = 64,
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic              wr_clk,
  input  logic              we,
  input  logic [AW-1:0]     waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              rd_clk,
  input  logic              re,
  input  logic [AW-1:0]     raddr,
  output logic [DATA_W-1:0] rdata
);

  logic [DATA_W-1:0] cell_q [DEPTH];
  logic [DATA_W-1:0] rdata_q;
  logic [DATA_W-1:0] rdata_d;

  always_ff @(posedge wr_clk) begin
    if (we) begin
      cell_q[waddr] <= wdata;
    end
  end

  always_comb begin
    rdata_d = rdata_q;
    if (re) begin
      rdata_d = cell_q[raddr];
    end
  end

  always_ff @(posedge rd_clk) begin
    rdata_q <= rdata_d;
  end

  assign rdata = rdata_q;

endmodule

// File: rtl/meso_wr_side.sv
module meso_wr_side #(
  parameter int AW = 6,
  localparam int PW = AW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic [PW-1:0] rgray_sync,
  output logic          we,
  output logic [AW-1:0] waddr,
  output logic [PW-1:0] wgray,
  output logic          full,
  output logic          ovf
);

  logic [PW-1:0] bin_q,  bin_d;
  logic [PW-1:0] gray_q, gray_d;
  logic          ovf_q,  ovf_d;
  logic          push;

  assign full = (gray_q == {~rgray_sync[PW-1:PW-2], rgray_sync[PW-3:0]});
  assign push = en & ~full;

  always_comb begin
    bin_d  = bin_q + PW'(push);
    gray_d = bin_d ^ (bin_d >> 1);
    ovf_d  = ovf_q | (en & full);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bin_q  <= '0;
      gray_q <= '0;
      ovf_q  <= 1'b0;
    end else begin
      bin_q  <= bin_d;
      gray_q <= gray_d;
      ovf_q  <= ovf_d;
    end
  end

  assign we    = push;
  assign waddr = bin_q[AW-1:0];
  assign wgray = gray_q;
  assign ovf   = ovf_q;

  // R6
  full_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && full) |=> $stable(bin_q));

  // R7
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_q |=> ovf_q);

  // R2
  gray_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(gray_q ^ $past(gray_q)) <= 1);

endmodule

// File: rtl/meso_rd_side.sv
module meso_rd_side
  import meso_fifo_pkg::*;
#(
  parameter int AW    = 6,
  parameter int GUARD = 4,
  localparam int PW   = AW + 1,
  localparam int CW   = $clog2(GUARD + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [PW-1:0] wgray_sync,
  output logic          pop,
  output logic [AW-1:0] raddr,
  output logic [PW-1:0] rgray,
  output logic          empty,
  output logic          valid,
  output logic          udf
);

  rd_state_e     state_q, state_d;
  logic [CW-1:0] cnt_q,   cnt_d;
  logic [PW-1:0] bin_q,   bin_d;
  logic [PW-1:0] gray_q,  gray_d;
  logic          valid_q, valid_d;
  logic          udf_q,   udf_d;

  assign empty = (gray_q == wgray_sync);
  assign pop   = (state_q == RD_RUN);

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    case (state_q)
      RD_IDLE: begin
        if (!empty) begin
          state_d = RD_GUARD;
          cnt_d   = '0;
        end
      end
      RD_GUARD: begin
        if (cnt_q == CW'(GUARD - 1)) begin
          state_d = RD_RUN;
        end else begin
          cnt_d = cnt_q + CW'(1);
        end
      end
      RD_RUN:  state_d = RD_RUN;
      default: state_d = RD_IDLE;
    endcase
  end

  always_comb begin
    bin_d   = bin_q + PW'(pop);
    gray_d  = bin_d ^ (bin_d >> 1);
    valid_d = pop;
    udf_d   = udf_q | (pop & empty);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= RD_IDLE;
      cnt_q   <= '0;
      bin_q   <= '0;
      gray_q  <= '0;
      valid_q <= 1'b0;
      udf_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      bin_q   <= bin_d;
      gray_q  <= gray_d;
      valid_q <= valid_d;
      udf_q   <= udf_d;
    end
  end

  assign raddr = bin_q[AW-1:0];
  assign rgray = gray_q;
  assign valid = valid_q;
  assign udf   = udf_q;

  // R4
  run_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    valid_q |=> valid_q);

  // R3
  start_has_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pop) |-> !empty);

  // R8
  udf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    udf_q |=> udf_q);

  // R2
  rd_gray_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(gray_q ^ $past(gray_q)) <= 1);

endmodule

// File: rtl/meso_fifo.sv
module meso_fifo #(
  parameter int DATA_W = 16,
  parameter int DEPTH  = 64,
  parameter int GUARD  = 4,
  localparam int AW    = $clog2(DEPTH),
  localparam int PW    = AW + 1
) (
  input  logic              wr_clk,
  input  logic              wr_rst_n,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  output logic              wr_full,
  output logic              wr_ovf_err,
  input  logic              rd_clk,
  input  logic              rd_rst_n,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_empty,
  output logic              rd_udf_err
);

  logic          we;
  logic [AW-1:0] waddr;
  logic [PW-1:0] wgray;
  logic [PW-1:0] wgray_in_rd;
  logic          pop;
  logic [AW-1:0] raddr;
  logic [PW-1:0] rgray;
  logic [PW-1:0] rgray_in_wr;

  meso_wr_side #(.AW(AW)) u_wr (
    .clk        (wr_clk),
    .rst_n      (wr_rst_n),
    .en         (wr_en),
    .rgray_sync (rgray_in_wr),
    .we         (we),
    .waddr      (waddr),
    .wgray      (wgray),
    .full       (wr_full),
    .ovf        (wr_ovf_err)
  );

  meso_sync #(.W(PW)) u_r2w (
    .clk   (wr_clk),
    .rst_n (wr_rst_n),
    .d     (rgray),
    .q     (rgray_in_wr)
  );

  meso_sync #(.W(PW)) u_w2r (
    .clk   (rd_clk),
    .rst_n (rd_rst_n),
    .d     (wgray),
    .q     (wgray_in_rd)
  );

  meso_rd_side #(.AW(AW), .GUARD(GUARD)) u_rd (
    .clk        (rd_clk),
    .rst_n      (rd_rst_n),
    .wgray_sync (wgray_in_rd),
    .pop        (pop),
    .raddr      (raddr),
    .rgray      (rgray),
    .empty      (rd_empty),
    .valid      (rd_valid),
    .udf        (rd_udf_err)
  );

  meso_mem #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_mem (
    .wr_clk (wr_clk),
    .we     (we),
    .waddr  (waddr),
    .wdata  (wr_data),
    .rd_clk (rd_clk),
    .re     (pop),
    .raddr  (raddr),
    .rdata  (rd_data)
  );

endmodule

// File: tb/sim_meso_fifo.sv
`timescale 1ns/1ps
module sim_meso_fifo;

  localparam int DW     = 16;
  localparam int DEPTH  = 64;
  localparam int GUARD  = 4;
  localparam int NWORDS = 100;

  logic          wr_clk;
  logic          rd_clk;
  logic          wr_rst_n, rd_rst_n;
  logic          wr_en;
  logic [DW-1:0] wr_data;
  logic          wr_full, wr_ovf_err;
  logic          rd_valid, rd_empty, rd_udf_err;
  logic [DW-1:0] rd_data;

  int checks = 0;
  int errors = 0;
  int cyc    = 0;
  int rd_shift = 0;

  meso_fifo #(.DATA_W(DW), .DEPTH(DEPTH), .GUARD(GUARD)) u0 (
    .wr_clk(wr_clk), .wr_rst_n(wr_rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .wr_full(wr_full), .wr_ovf_err(wr_ovf_err),
    .rd_clk(rd_clk), .rd_rst_n(rd_rst_n), .rd_valid(rd_valid),
    .rd_data(rd_data), .rd_empty(rd_empty), .rd_udf_err(rd_udf_err)
  );

  initial wr_clk = 1'b0;
  always #4 wr_clk = ~wr_clk;

  always begin
    rd_clk = 1'b0;
    #4;
    rd_clk = 1'b1;
    #4;
    if (rd_shift > 0) begin
      #(rd_shift);
      rd_shift = 0;
    end
  end

  task automatic chk(string req, string what, longint act, longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  always @(posedge wr_clk) begin
    cyc++;
    if (cyc > 150000) begin
      errors++;
      $display("FAIL R2 watchdog: actual %0d cycles expected fewer", cyc);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic reset_both(int shift);
    wr_en    = 1'b0;
    wr_data  = '0;
    wr_rst_n = 1'b0;
    rd_rst_n = 1'b0;
    rd_shift = shift;
    repeat (4) @(negedge wr_clk);
    chk("R1", "empty in reset", rd_empty, 1);
    chk("R1", "valid in reset", rd_valid, 0);
    chk("R1", "full in reset", wr_full, 0);
    chk("R1", "ovf in reset", wr_ovf_err, 0);
    chk("R1", "udf in reset", rd_udf_err, 0);
  endtask

  task automatic run_stream(int shift);
    int lat;
    reset_both(shift);
    @(negedge wr_clk) wr_rst_n = 1'b1;
    @(negedge rd_clk) rd_rst_n = 1'b1;
    chk("R1", "empty after release", rd_empty, 1);
    fork
      begin
        for (int i = 0; i < NWORDS; i++) begin
          @(negedge wr_clk);
          wr_en   = 1'b1;
          wr_data = DW'(i);
        end
        @(negedge wr_clk) wr_en = 1'b0;
      end
      begin
        while (rd_empty) @(negedge rd_clk);
        lat = 0;
        while (!rd_valid && lat < 50) begin
          @(negedge rd_clk);
          lat++;
        end
        chk("R3", "guard latency", lat, GUARD + 2);
        for (int j = 0; j < NWORDS; j++) begin
          if (j > 0) @(negedge rd_clk);
          if (j == NWORDS / 2) rd_shift = 1;
          chk("R4", "valid held", rd_valid, 1);
          chk("R2", "word order", rd_data, j);
        end
        chk("R8", "no underflow while fed", rd_udf_err, 0);
        repeat (12) @(negedge rd_clk);
        chk("R8", "underflow after writer stops", rd_udf_err, 1);
        chk("R4", "valid held after drain", rd_valid, 1);
      end
    join
  endtask

  task automatic wr_word(logic [DW-1:0] d);
    @(negedge wr_clk);
    wr_en   = 1'b1;
    wr_data = d;
    @(negedge wr_clk);
    wr_en   = 1'b0;
  endtask

  task automatic run_overflow();
    int wait_n;
    reset_both(0);
    @(negedge wr_clk) wr_rst_n = 1'b1;
    for (int i = 0; i < DEPTH - 1; i++) wr_word(DW'(i));
    chk("R5", "full before last slot", wr_full, 0);
    wr_word(DW'(DEPTH - 1));
    chk("R5", "full at depth", wr_full, 1);
    chk("R7", "no ovf before extra write", wr_ovf_err, 0);
    wr_word(16'hBEEF);
    chk("R7", "ovf after write at full", wr_ovf_err, 1);
    chk("R6", "still full after dropped write", wr_full, 1);
    @(negedge rd_clk) rd_rst_n = 1'b1;
    wait_n = 0;
    while (!rd_valid && wait_n < 50) begin
      @(negedge rd_clk);
      wait_n++;
    end
    for (int j = 0; j < DEPTH; j++) begin
      if (j > 0) @(negedge rd_clk);
      chk("R6", "stored word intact", rd_data, j);
    end
    chk("R7", "ovf sticky after reads", wr_ovf_err, 1);
    @(negedge wr_clk) wr_rst_n = 1'b0;
    @(negedge wr_clk) wr_rst_n = 1'b1;
    @(negedge wr_clk);
    chk("R1", "ovf cleared by write reset", wr_ovf_err, 0);
  endtask

  initial begin
    for (int s = 0; s < 8; s++) run_stream(s);
    run_overflow();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule